// File: doc/BRIEF.md
# Address Translation Unit with TLB and Page-Table Walk

This block turns virtual byte addresses into physical addresses. Each request first searches a four-entry, fully associative translation cache. If no entry matches, a sixteen-entry page table held in registers is read on the next cycle. A valid page-table entry supplies the physical page number. An invalid entry means the page is not resident. In that case the block allocates a fresh physical page numbered one above the highest page number currently mapped, marks the entry valid, and uses it. Every response carries a three-way outcome code (cache hit, table hit, or fault), or an error flag when the page number lies outside the table.

Software or a test harness presets both structures through two load ports. A mode input picks the page size: 4 KB pages with a 12-bit offset, or 16 KB pages with a 14-bit offset. The mode should only be changed when the tables hold mappings made for that page size.

Top module: `atu_top`

## Requirements
- R1: After reset, `rsp_valid` and `busy` are low, every cache entry is invalid, and every page-table entry is invalid. The cache recency order after reset runs from entry 0 (most recent) to entry 3 (least recent).
- R2: A request accepted while `busy` is low whose page number matches a valid cache entry gives, one clock edge later, `rsp_valid`=1, `rsp_kind`=1 and `rsp_err`=0. `rsp_paddr` is the cached physical page number placed above the unchanged offset.
- R3: With `page_mode`=0 the page number is `req_vaddr[19:12]` and the offset is bits 11:0. With `page_mode`=1 the page number is `req_vaddr[19:14]` and the offset is bits 13:0. In both modes `rsp_paddr` = {page number, offset}, zero-extended to 22 bits.
- R4: On a cache miss where the page-table entry is valid, the response arrives two edges after acceptance with `rsp_kind`=2. The translation is written into the cache, so a repeat access to the same page is a cache hit.
- R5: On a cache miss where the page-table entry is invalid, the response arrives two edges after acceptance with `rsp_kind`=3. The new physical page number is the largest number among valid page-table entries plus one, or 0 when no entry is valid. The page-table entry becomes valid with that number, and the cache is filled.
- R6: A cache fill takes the lowest-numbered invalid entry if one exists, and otherwise the least recently used entry. Cache hits, fills and loads each make the touched entry the most recent.
- R7: A page number of 16 or more gives, one edge after acceptance, `rsp_valid`=1, `rsp_err`=1, `rsp_kind`=0 and `rsp_paddr`=0, and changes neither structure.
- R8: `busy` is high for exactly the one cycle of a table walk. A request presented while `busy` is high is ignored and produces no response.
- R9: A load-port write replaces the addressed cache or page-table entry on the next edge, and a cache load makes that entry the most recent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 20 | Virtual byte address |
| page_mode | input | 1 | 0: 4 KB pages, 1: 16 KB pages |
| busy | output | 1 | Table walk in progress; requests ignored |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_kind | output | 2 | 0 none/error, 1 cache hit, 2 table hit, 3 fault |
| rsp_paddr | output | 22 | Physical byte address |
| rsp_err | output | 1 | Page number out of table range |
| tlb_ld_en | input | 1 | Cache entry load strobe |
| tlb_ld_idx | input | 2 | Cache entry index to load |
| tlb_ld_valid | input | 1 | Valid bit to load |
| tlb_ld_tag | input | 8 | Virtual page number to load |
| tlb_ld_ppn | input | 8 | Physical page number to load |
| pt_ld_en | input | 1 | Page-table entry load strobe |
| pt_ld_idx | input | 4 | Page-table index to load |
| pt_ld_valid | input | 1 | Valid bit to load |
| pt_ld_ppn | input | 8 | Physical page number to load |

## Verification
A preloaded cache and page table are driven with an address stream in 4 KB mode. The stream produces cache hits, table hits that fill an empty cache slot, faults that evict the least recent entry, and a later access to an evicted page. That last access tells a correct recency order and a correct table update apart from wrong ones. Faults from an empty table show the allocation rule at its floor of zero. Out-of-range addresses and a request held high during a walk show that the error path and the busy path leave state alone. The same stream is then replayed in 16 KB mode, so that offset width and page-number split are checked separately from the lookup logic.

// File: rtl/atu_pkg.sv
package atu_pkg;
    parameter int VA_W      = 20;
    parameter int PPN_W     = 8;
    parameter int PT_DEPTH  = 16;
    parameter int TLB_N     = 4;
    parameter int OFF_SMALL = 12;
    parameter int OFF_LARGE = 14;

    localparam int VPN_W     = VA_W - OFF_SMALL;
    localparam int PA_W      = PPN_W + OFF_LARGE;
    localparam int PT_IDX_W  = $clog2(PT_DEPTH);
    localparam int TLB_IDX_W = $clog2(TLB_N);

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_TLB   = 2'd1,
        KIND_PT    = 2'd2,
        KIND_FAULT = 2'd3
    } xlat_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } atu_state_e;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } tlb_entry_t;

    typedef struct packed {
        logic             valid;
        logic [PPN_W-1:0] ppn;
    } pt_entry_t;

    function automatic logic [VPN_W-1:0] vpn_of(logic [VA_W-1:0] va, logic big);
        return big ? VPN_W'(va >> OFF_LARGE) : VPN_W'(va >> OFF_SMALL);
    endfunction

    function automatic logic [OFF_LARGE-1:0] off_of(logic [VA_W-1:0] va, logic big);
        return big ? va[OFF_LARGE-1:0] : OFF_LARGE'(va[OFF_SMALL-1:0]);
    endfunction

    function automatic logic [PA_W-1:0] make_paddr(logic [PPN_W-1:0] ppn,
                                                   logic [OFF_LARGE-1:0] off,
                                                   logic big);
        return big ? PA_W'({ppn, off}) : PA_W'({ppn, off[OFF_SMALL-1:0]});
    endfunction
endpackage

// File: rtl/atu_tlb_array.sv
module atu_tlb_array
    import atu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [VPN_W-1:0]     look_vpn,
    output logic                 look_hit,
    output logic [TLB_IDX_W-1:0] look_idx,
    output logic [PPN_W-1:0]     look_ppn,
    input  logic                 hit_touch,
    input  logic                 fill_en,
    input  logic [VPN_W-1:0]     fill_vpn,
    input  logic [PPN_W-1:0]     fill_ppn,
    input  logic                 ld_en,
    input  logic [TLB_IDX_W-1:0] ld_idx,
    input  tlb_entry_t           ld_entry
);
    tlb_entry_t             ent [TLB_N];
    logic [TLB_IDX_W-1:0]   age [TLB_N];
    logic [TLB_N-1:0]       match_vec;
    logic [TLB_N-1:0]       free_vec;
    logic [TLB_N-1:0]       oldest_vec;
    logic [TLB_IDX_W-1:0]   victim;
    logic                   wr_en;
    logic [TLB_IDX_W-1:0]   wr_idx;
    tlb_entry_t             wr_data;
    logic                   touch_en;
    logic [TLB_IDX_W-1:0]   touch_idx;

    for (genvar g = 0; g < TLB_N; g++) begin : g_slot
        assign match_vec[g]  = ent[g].valid && (ent[g].tag == look_vpn);
        assign free_vec[g]   = !ent[g].valid;
        assign oldest_vec[g] = (age[g] == TLB_IDX_W'(TLB_N - 1));
    end

    always_comb begin
        look_idx = '0;
        for (int i = TLB_N - 1; i >= 0; i--) begin
            if (match_vec[i]) look_idx = TLB_IDX_W'(i);
        end
    end
    assign look_hit = |match_vec;
    assign look_ppn = ent[look_idx].ppn;

    always_comb begin
        victim = '0;
        if (|free_vec) begin
            for (int i = TLB_N - 1; i >= 0; i--) begin
                if (free_vec[i]) victim = TLB_IDX_W'(i);
            end
        end else begin
            for (int i = 0; i < TLB_N; i++) begin
                if (oldest_vec[i]) victim = TLB_IDX_W'(i);
            end
        end
    end

    always_comb begin
        wr_en   = ld_en || fill_en;
        wr_idx  = ld_en ? ld_idx : victim;
        wr_data = ld_entry;
        if (!ld_en) begin
            wr_data.valid = 1'b1;
            wr_data.tag   = fill_vpn;
            wr_data.ppn   = fill_ppn;
        end
        touch_en  = wr_en || hit_touch;
        touch_idx = wr_en ? wr_idx : look_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TLB_N; i++) begin
                ent[i] <= '0;
                age[i] <= TLB_IDX_W'(i);
            end
        end else begin
            if (wr_en) ent[wr_idx] <= wr_data;
            if (touch_en) begin
                for (int i = 0; i < TLB_N; i++) begin
                    if (TLB_IDX_W'(i) == touch_idx)
                        age[i] <= '0;
                    else if (age[i] < age[touch_idx])
                        age[i] <= age[i] + TLB_IDX_W'(1);
                end
            end
        end
    end

    logic [TLB_IDX_W-1:0] chk_fill_idx;
    logic [VPN_W-1:0]     chk_fill_vpn;
    always_ff @(posedge clk) begin
        chk_fill_idx <= victim;
        chk_fill_vpn <= fill_vpn;
    end

    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest_vec) == 1); // R6

    AST_FILL_IS_MRU: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !ld_en) |=> (age[chk_fill_idx] == '0)
                                && ent[chk_fill_idx].valid
                                && (ent[chk_fill_idx].tag == chk_fill_vpn)); // R6

    AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        hit_touch |-> ($countones(match_vec) == 1)); // R2
endmodule

// File: rtl/atu_page_table.sv
module atu_page_table
    import atu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [PT_IDX_W-1:0] rd_idx,
    output pt_entry_t           rd_entry,
    output logic [PPN_W-1:0]    next_ppn,
    input  logic                alloc_en,
    input  logic                ld_en,
    input  logic [PT_IDX_W-1:0] ld_idx,
    input  pt_entry_t           ld_entry
);
    pt_entry_t        ent [PT_DEPTH];
    logic             any_valid;
    logic [PPN_W-1:0] max_ppn;

    assign rd_entry = ent[rd_idx];

    always_comb begin
        any_valid = 1'b0;
        max_ppn   = '0;
        for (int i = 0; i < PT_DEPTH; i++) begin
            if (ent[i].valid) begin
                if (!any_valid || (ent[i].ppn > max_ppn)) max_ppn = ent[i].ppn;
                any_valid = 1'b1;
            end
        end
        next_ppn = any_valid ? max_ppn + PPN_W'(1) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PT_DEPTH; i++) ent[i] <= '0;
        end else if (ld_en) begin
            ent[ld_idx] <= ld_entry;
        end else if (alloc_en) begin
            ent[rd_idx].valid <= 1'b1;
            ent[rd_idx].ppn   <= next_ppn;
        end
    end

    logic [PT_IDX_W-1:0] chk_idx;
    logic [PPN_W-1:0]    chk_ppn;
    always_ff @(posedge clk) begin
        chk_idx <= rd_idx;
        chk_ppn <= next_ppn;
    end

    AST_ALLOC_ON_INVALID: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> !rd_entry.valid); // R5

    AST_ALLOC_MAPS_PAGE: assert property (@(posedge clk) disable iff (rst)
        (alloc_en && !ld_en) |=> ent[chk_idx].valid && (ent[chk_idx].ppn == chk_ppn)); // R5
endmodule

// File: rtl/atu_top.sv
module atu_top
    import atu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic                 page_mode,
    output logic                 busy,
    output logic                 rsp_valid,
    output logic [1:0]           rsp_kind,
    output logic [PA_W-1:0]      rsp_paddr,
    output logic                 rsp_err,
    input  logic                 tlb_ld_en,
    input  logic [TLB_IDX_W-1:0] tlb_ld_idx,
    input  logic                 tlb_ld_valid,
    input  logic [VPN_W-1:0]     tlb_ld_tag,
    input  logic [PPN_W-1:0]     tlb_ld_ppn,
    input  logic                 pt_ld_en,
    input  logic [PT_IDX_W-1:0]  pt_ld_idx,
    input  logic                 pt_ld_valid,
    input  logic [PPN_W-1:0]     pt_ld_ppn
);
    atu_state_e             state;
    logic [PT_IDX_W-1:0]    walk_idx;
    logic [OFF_LARGE-1:0]   walk_off;
    logic                   walk_big;

    logic [VPN_W-1:0]       vpn_in;
    logic [OFF_LARGE-1:0]   off_in;
    logic                   in_range;
    logic                   accept;

    logic                   look_hit;
    logic [TLB_IDX_W-1:0]   look_idx;
    logic [PPN_W-1:0]       look_ppn;
    logic                   hit_touch;
    logic                   in_walk;
    logic                   fill_en;
    logic [PPN_W-1:0]       walk_ppn;
    logic                   alloc_en;
    pt_entry_t              pt_rd;
    logic [PPN_W-1:0]       next_ppn;
    tlb_entry_t             tlb_ld_entry;
    pt_entry_t              pt_ld_entry;

    assign vpn_in    = vpn_of(req_vaddr, page_mode);
    assign off_in    = off_of(req_vaddr, page_mode);
    assign in_range  = (vpn_in < VPN_W'(PT_DEPTH));
    assign accept    = req_valid && (state == ST_IDLE);
    assign hit_touch = accept && in_range && look_hit;
    assign in_walk   = (state == ST_WALK);
    assign fill_en   = in_walk;
    assign alloc_en  = in_walk && !pt_rd.valid;
    assign walk_ppn  = pt_rd.valid ? pt_rd.ppn : next_ppn;
    assign busy      = in_walk;

    always_comb begin
        tlb_ld_entry.valid = tlb_ld_valid;
        tlb_ld_entry.tag   = tlb_ld_tag;
        tlb_ld_entry.ppn   = tlb_ld_ppn;
        pt_ld_entry.valid  = pt_ld_valid;
        pt_ld_entry.ppn    = pt_ld_ppn;
    end

    atu_tlb_array i_tlb (
        .clk       (clk),
        .rst       (rst),
        .look_vpn  (vpn_in),
        .look_hit  (look_hit),
        .look_idx  (look_idx),
        .look_ppn  (look_ppn),
        .hit_touch (hit_touch),
        .fill_en   (fill_en),
        .fill_vpn  (VPN_W'(walk_idx)),
        .fill_ppn  (walk_ppn),
        .ld_en     (tlb_ld_en),
        .ld_idx    (tlb_ld_idx),
        .ld_entry  (tlb_ld_entry)
    );

    atu_page_table i_pt (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (walk_idx),
        .rd_entry (pt_rd),
        .next_ppn (next_ppn),
        .alloc_en (alloc_en),
        .ld_en    (pt_ld_en),
        .ld_idx   (pt_ld_idx),
        .ld_entry (pt_ld_entry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            walk_idx  <= '0;
            walk_off  <= '0;
            walk_big  <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_kind  <= KIND_NONE;
            rsp_paddr <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (!in_range) begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                            rsp_kind  <= KIND_NONE;
                            rsp_paddr <= '0;
                        end else if (look_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b0;
                            rsp_kind  <= KIND_TLB;
                            rsp_paddr <= make_paddr(look_ppn, off_in, page_mode);
                        end else begin
                            state    <= ST_WALK;
                            walk_idx <= vpn_in[PT_IDX_W-1:0];
                            walk_off <= off_in;
                            walk_big <= page_mode;
                        end
                    end
                end
                ST_WALK: begin
                    rsp_valid <= 1'b1;
                    rsp_err   <= 1'b0;
                    rsp_kind  <= pt_rd.valid ? KIND_PT : KIND_FAULT;
                    rsp_paddr <= make_paddr(walk_ppn, walk_off, walk_big);
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_HIT_NEXT_EDGE: assert property (@(posedge clk) disable iff (rst)
        hit_touch |=> rsp_valid && (rsp_kind == KIND_TLB) && !rsp_err); // R2

    AST_MISS_WALKS: assert property (@(posedge clk) disable iff (rst)
        (accept && in_range && !look_hit) |=> busy && !rsp_valid); // R4

    AST_WALK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy && rsp_valid && !rsp_err); // R8

    AST_ERR_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_kind == KIND_NONE) && (rsp_paddr == '0)); // R7

    AST_RANGE_ERR: assert property (@(posedge clk) disable iff (rst)
        (accept && !in_range) |=> rsp_valid && rsp_err && !busy); // R7
endmodule

// File: tb/test_atu_top.sv
module test_atu_top;
    import atu_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 req_valid = 1'b0;
    logic [VA_W-1:0]      req_vaddr = '0;
    logic                 page_mode = 1'b0;
    logic                 busy;
    logic                 rsp_valid;
    logic [1:0]           rsp_kind;
    logic [PA_W-1:0]      rsp_paddr;
    logic                 rsp_err;
    logic                 tlb_ld_en = 1'b0;
    logic [TLB_IDX_W-1:0] tlb_ld_idx = '0;
    logic                 tlb_ld_valid = 1'b0;
    logic [VPN_W-1:0]     tlb_ld_tag = '0;
    logic [PPN_W-1:0]     tlb_ld_ppn = '0;
    logic                 pt_ld_en = 1'b0;
    logic [PT_IDX_W-1:0]  pt_ld_idx = '0;
    logic                 pt_ld_valid = 1'b0;
    logic [PPN_W-1:0]     pt_ld_ppn = '0;

    always #10 clk = ~clk;

    atu_top i_atu_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .page_mode(page_mode), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_kind(rsp_kind), .rsp_paddr(rsp_paddr), .rsp_err(rsp_err),
        .tlb_ld_en(tlb_ld_en), .tlb_ld_idx(tlb_ld_idx), .tlb_ld_valid(tlb_ld_valid),
        .tlb_ld_tag(tlb_ld_tag), .tlb_ld_ppn(tlb_ld_ppn),
        .pt_ld_en(pt_ld_en), .pt_ld_idx(pt_ld_idx), .pt_ld_valid(pt_ld_valid),
        .pt_ld_ppn(pt_ld_ppn)
    );

    typedef struct {
        int    kind;
        longint paddr;
        bit    err;
        int    due;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   cyc      = 0;

    // reference model state
    bit   m_tv [4];
    int   m_tt [4];
    int   m_tp [4];
    int   m_ord[$];
    bit   m_pv [16];
    int   m_pp [16];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, string what, longint act, longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    task automatic m_touch(int idx);
        for (int k = 0; k < m_ord.size(); k++) begin
            if (m_ord[k] == idx) begin
                m_ord.delete(k);
                break;
            end
        end
        m_ord.push_front(idx);
    endtask

    task automatic m_reset();
        m_ord.delete();
        for (int k = 0; k < 4; k++) begin
            m_tv[k] = 0; m_tt[k] = 0; m_tp[k] = 0;
            m_ord.push_back(k);
        end
        for (int k = 0; k < 16; k++) begin
            m_pv[k] = 0; m_pp[k] = 0;
        end
    endtask

    // monitor: compare every response against the scoreboard head
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb.size() == 0) begin
                check(0, "R8", "unexpected response paddr", rsp_paddr, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_kind == 2'(e.kind), e.tag, "kind", rsp_kind, e.kind);
                check(rsp_paddr == PA_W'(e.paddr), e.tag, "paddr", rsp_paddr, e.paddr);
                check(rsp_err == e.err, e.tag, "err", rsp_err, e.err);
                check(cyc == e.due, e.tag, "response cycle", cyc, e.due);
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_reset();
        @(negedge clk);
    endtask

    task automatic load_tlb(int idx, bit v, int tag, int ppn);
        @(negedge clk);
        tlb_ld_en = 1'b1; tlb_ld_idx = TLB_IDX_W'(idx); tlb_ld_valid = v;
        tlb_ld_tag = VPN_W'(tag); tlb_ld_ppn = PPN_W'(ppn);
        @(negedge clk);
        tlb_ld_en = 1'b0;
        m_tv[idx] = v; m_tt[idx] = tag; m_tp[idx] = ppn;
        m_touch(idx);
    endtask

    task automatic load_pt(int idx, bit v, int ppn);
        @(negedge clk);
        pt_ld_en = 1'b1; pt_ld_idx = PT_IDX_W'(idx); pt_ld_valid = v; pt_ld_ppn = PPN_W'(ppn);
        @(negedge clk);
        pt_ld_en = 1'b0;
        m_pv[idx] = v; m_pp[idx] = ppn;
    endtask

    // compute expectation from the requirements and update the model
    task automatic predict(int va, bit big, string tag, int now);
        exp_t e;
        int vpn, off, ob, hit, ppn, mx, victim;
        bit any;
        ob  = big ? 14 : 12;
        vpn = va >> ob;
        off = va & ((1 << ob) - 1);
        e.tag = tag; e.err = 0; e.kind = 0; e.paddr = 0;
        if (vpn >= 16) begin
            e.err = 1; e.due = now + 1;
        end else begin
            hit = -1;
            for (int k = 0; k < 4; k++) if (m_tv[k] && m_tt[k] == vpn) hit = k;
            if (hit >= 0) begin
                e.kind = 1; ppn = m_tp[hit]; e.due = now + 1;
                m_touch(hit);
            end else begin
                e.due = now + 2;
                if (m_pv[vpn]) begin
                    e.kind = 2; ppn = m_pp[vpn];
                end else begin
                    e.kind = 3;
                    any = 0; mx = 0;
                    for (int k = 0; k < 16; k++)
                        if (m_pv[k] && (!any || m_pp[k] > mx)) begin mx = m_pp[k]; any = 1; end
                    ppn = any ? mx + 1 : 0;
                    m_pv[vpn] = 1; m_pp[vpn] = ppn;
                end
                victim = -1;
                for (int k = 3; k >= 0; k--) if (!m_tv[k]) victim = k;
                if (victim < 0) victim = m_ord[m_ord.size() - 1];
                m_tv[victim] = 1; m_tt[victim] = vpn; m_tp[victim] = ppn;
                m_touch(victim);
            end
            e.paddr = (longint'(ppn) << ob) | off;
        end
        sb.push_back(e);
    endtask

    task automatic issue(int va, bit big, string tag);
        @(negedge clk);
        while (busy) @(negedge clk);
        predict(va, big, tag, cyc);
        req_valid = 1'b1; req_vaddr = VA_W'(va); page_mode = big;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    task automatic preload();
        int pv [16] = '{1,0,0,1,1,1,0,1,0,0,1,1,0,0,0,0};
        int pp [16] = '{5,0,0,6,9,11,0,4,0,0,3,12,0,0,0,0};
        load_tlb(0, 1, 11, 12);
        load_tlb(1, 1, 7, 4);
        load_tlb(2, 1, 3, 6);
        load_tlb(3, 0, 4, 9);
        for (int k = 0; k < 16; k++) load_pt(k, pv[k] != 0, pp[k]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "WD", "watchdog expired cycle", cyc, 0);
        report();
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        // R1/R5: empty table, allocation starts at page 0 and climbs
        issue(32'h05123, 0, "R5_empty_table");
        issue(32'h06abc, 0, "R5_second_alloc");
        issue(32'h05fff, 0, "R6_fill_then_hit");
        drain();

        // 4 KB mode with preloaded state
        do_reset();
        preload();
        issue(12648, 0, "R9_loaded_hit");
        issue(45419, 0, "R2_hit");
        issue(46824, 0, "R3_small_offset");
        issue(16975, 0, "R4_table_hit_fills_free");
        issue(40004, 0, "R5_fault_above_max");
        issue(12707, 0, "R2_hit_again");
        issue(52236, 0, "R6_fault_evicts_lru");
        issue(45419, 0, "R6_evicted_page_rewalk");
        issue(40004, 0, "R4_fill_now_hits");
        issue(30000, 0, "R4_table_hit_after_fill");
        issue(32'h10000, 0, "R7_first_out_of_range");
        issue(32'hFFFFF, 0, "R7_top_address");
        issue(52236, 0, "R7_state_unchanged");
        drain();

        // R8: request held while busy is ignored
        @(negedge clk);
        predict(32'h0D000, 0, "R8_walk", cyc);
        req_valid = 1'b1; req_vaddr = VA_W'(32'h0D000); page_mode = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, "R8", "busy during walk", busy, 1);
        req_vaddr = VA_W'(12648);
        @(negedge clk);
        req_valid = 1'b0;
        drain();
        check(sb.size() == 0, "R8", "pending expectations", sb.size(), 0);

        // 16 KB mode
        do_reset();
        preload();
        issue(12648, 1, "R3_large_table_hit");
        issue(45419, 1, "R3_large_fault");
        issue(46824, 1, "R3_large_hit");
        issue(16975, 1, "R3_large_fault2");
        issue(40004, 1, "R3_large_hit2");
        issue(12707, 1, "R3_large_hit3");
        issue(52236, 1, "R3_large_page3");
        issue(32'h3FFFF, 1, "R5_large_last_page");
        issue(32'h40000, 1, "R7_large_out_of_range");
        drain();
        check(sb.size() == 0, "R8", "pending expectations at end", sb.size(), 0);

        report();
        $finish;
    end
endmodule